// File: doc/BRIEF.md
# Multi-Port Distributed RAM with Asymmetric Read Widths

This block is a small distributed memory with one synchronous write port and eight combinational read ports. The storage is eight columns, each 32 entries of 2 bits. A single 16-bit write word fills all eight columns at once, at one shared 5-bit address.

Seven narrow read ports, numbered 0 to 6, each see their own column as 64 entries of 1 bit and use a 6-bit address. The eighth column is read through a wide port that reuses the write address and returns the whole 2-bit entry. A typical use is a shallow table that is written one full word at a time and looked up bit by bit from several places at once.

A parameter moves the write onto the falling clock edge. Another parameter sets the power-up contents. Nothing clears the contents at run time.

Top module: `mrport_dram`

## Requirements
- R1: On the active write clock edge with `we` high, all eight 2-bit columns are written together at the entry that `wr_addr` selects.
- R2: On an active edge with `we` low, no entry changes. All eight ports read the same values before and after such an edge.
- R3: Narrow port k (k = 0 to 6) takes its 6-bit address from `nr_addr[6k+5:6k]`. Bits [5:1] of that address pick the entry, and bit 0 picks the stored bit: 0 returns bit 0 of the entry and 1 returns bit 1.
- R4: `wide_data` returns the full 2-bit entry of column 7 at `wr_addr`.
- R5: All reads are combinational from address to data. A port that reads the entry being written shows the old data before the active edge and the new data right after it.
- R6: With `WCLK_INV` at 0 (the default), writes take place on the rising edge of `wclk`. With `WCLK_INV` at 1, they take place on the falling edge.
- R7: At power-up, every entry holds `INIT_WORD`, whose default value is all zeros. No input clears the contents.
- R8: Bits `wr_data[2k+1:2k]` go into column k. Narrow port k reads only column k, and the wide port reads only column 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| we | input | 1 | Write enable |
| wr_addr | input | 5 | Shared write address, also the wide port's read address |
| wr_data | input | 16 | Write word; 2 bits per column |
| nr_addr | input | 42 | Seven 6-bit narrow read addresses, port k at bits [6k+5:6k] |
| nr_data | output | 7 | Narrow read data, bit k from port k |
| wide_data | output | 2 | Wide read data, column 7 |

## Verification
The bench sweeps every entry and both halves of each entry through all seven narrow ports. A design with swapped bit selection or a misrouted column fails that sweep at once. It writes at entries 0 and 31 with alternating bit patterns, so a decoder that drops an address bit overwrites a neighbour that is checked later. It performs write-disabled edges with different data on the bus; a design that ignores `we` returns that data. A second instance with the clock inverted is checked between the falling and the rising edge, so a design whose write edge does not follow the parameter shows the wrong contents in that window.

// File: rtl/mrport_dram_pkg.sv
package mrport_dram_pkg;

    // Pick one bit out of a stored entry, selected by the low address bits.
    function automatic logic pick_bit(input logic [1:0] entry, input logic sel);
        pick_bit = sel ? entry[1] : entry[0];
    endfunction

endpackage

// File: rtl/mrport_dram_column.sv
module mrport_dram_column #(
    parameter int              ADDR_W   = 5,
    parameter int              COL_W    = 2,
    parameter bit              NEG_EDGE = 1'b0,
    parameter logic [COL_W-1:0] INIT_COL = '0
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [COL_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [COL_W-1:0]  rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [COL_W-1:0] mem [DEPTH];

    // Power-up contents; there is no run-time clear.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = INIT_COL;
        end
    end

    generate
        if (NEG_EDGE) begin : g_fall
            always_ff @(negedge wclk) begin
                if (we) begin
                    mem[waddr] <= wdata;
                end
            end
        end else begin : g_rise
            always_ff @(posedge wclk) begin
                if (we) begin
                    mem[waddr] <= wdata;
                end
            end
        end
    endgenerate

    // Combinational read.
    assign rword = mem[raddr];

endmodule

// File: rtl/mrport_dram_narrow.sv
module mrport_dram_narrow #(
    parameter int ADDR_W = 5,
    parameter int SEL_W  = 1
) (
    input  logic [ADDR_W+SEL_W-1:0] naddr,
    input  logic [1:0]              entry,
    output logic [ADDR_W-1:0]       word_addr,
    output logic                    bit_out
);
    import mrport_dram_pkg::*;

    // Upper bits address the entry; the low bit picks the half.
    assign word_addr = naddr[ADDR_W+SEL_W-1:SEL_W];
    assign bit_out   = pick_bit(entry, naddr[0]);

endmodule

// File: rtl/mrport_dram.sv
module mrport_dram #(
    parameter int ADDR_W   = 5,
    parameter int COL_W    = 2,
    parameter int NCOL     = 8,
    parameter bit WCLK_INV = 1'b0,
    parameter logic [NCOL*COL_W-1:0] INIT_WORD = '0
) (
    input  logic                            wclk,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [NCOL*COL_W-1:0]           wr_data,
    input  logic [(NCOL-1)*(ADDR_W+1)-1:0]  nr_addr,
    output logic [NCOL-2:0]                 nr_data,
    output logic [COL_W-1:0]                wide_data
);
    localparam int SEL_W = 1;
    localparam int NA_W  = ADDR_W + SEL_W;
    localparam int NNAR  = NCOL - 1;

    // Narrow columns, one per narrow read port.
    generate
        for (genvar k = 0; k < NNAR; k++) begin : g_nar
            logic [ADDR_W-1:0] waddr_k;
            logic [COL_W-1:0]  entry_k;

            mrport_dram_narrow #(
                .ADDR_W (ADDR_W),
                .SEL_W  (SEL_W)
            ) u_sel (
                .naddr     (nr_addr[k*NA_W +: NA_W]),
                .entry     (entry_k),
                .word_addr (waddr_k),
                .bit_out   (nr_data[k])
            );

            mrport_dram_column #(
                .ADDR_W   (ADDR_W),
                .COL_W    (COL_W),
                .NEG_EDGE (WCLK_INV),
                .INIT_COL (INIT_WORD[k*COL_W +: COL_W])
            ) u_col (
                .wclk  (wclk),
                .we    (we),
                .waddr (wr_addr),
                .wdata (wr_data[k*COL_W +: COL_W]),
                .raddr (waddr_k),
                .rword (entry_k)
            );
        end
    endgenerate

    // Wide column: read at the write address.
    mrport_dram_column #(
        .ADDR_W   (ADDR_W),
        .COL_W    (COL_W),
        .NEG_EDGE (WCLK_INV),
        .INIT_COL (INIT_WORD[NNAR*COL_W +: COL_W])
    ) u_wide (
        .wclk  (wclk),
        .we    (we),
        .waddr (wr_addr),
        .wdata (wr_data[NNAR*COL_W +: COL_W]),
        .raddr (wr_addr),
        .rword (wide_data)
    );

endmodule

// File: rtl/mrport_dram_chk.sv
module mrport_dram_chk #(
    parameter int ADDR_W   = 5,
    parameter int COL_W    = 2,
    parameter int NCOL     = 8,
    parameter bit WCLK_INV = 1'b0
) (
    input logic                            wclk,
    input logic                            we,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [NCOL*COL_W-1:0]           wr_data,
    input logic [(NCOL-1)*(ADDR_W+1)-1:0]  nr_addr,
    input logic [NCOL-2:0]                 nr_data,
    input logic [COL_W-1:0]                wide_data
);
    localparam int NA_W = ADDR_W + 1;

    logic act_clk;
    assign act_clk = wclk ^ WCLK_INV;

    logic armed = 1'b0;
    always_ff @(posedge act_clk) armed <= 1'b1;

    // R1 / R4: a write shows up on the wide port on the next edge.
    a_r1_wide_write: assert property (@(posedge act_clk) disable iff (!armed)
        we |=> (wr_addr != $past(wr_addr)) ||
               (wide_data == $past(wr_data[(NCOL-1)*COL_W +: COL_W])));

    // R2: without we, the wide entry at a steady address holds.
    a_r2_hold_wide: assert property (@(posedge act_clk) disable iff (!armed)
        !we |=> (wr_addr != $past(wr_addr)) || (wide_data == $past(wide_data)));

    generate
        for (genvar k = 0; k < NCOL-1; k++) begin : g_chk
            // R3 / R8: narrow port k returns the written bit of column k.
            a_r3_narrow_write: assert property (@(posedge act_clk) disable iff (!armed)
                (we && nr_addr[k*NA_W+1 +: ADDR_W] == wr_addr)
                |=> !$stable(nr_addr[k*NA_W +: NA_W]) ||
                    (nr_data[k] == $past(wr_data[k*COL_W + nr_addr[k*NA_W]])));

            // R2: narrow port at a steady address holds when not written.
            a_r2_hold_narrow: assert property (@(posedge act_clk) disable iff (!armed)
                !we |=> !$stable(nr_addr[k*NA_W +: NA_W]) ||
                        (nr_data[k] == $past(nr_data[k])));
        end
    endgenerate

endmodule

bind mrport_dram mrport_dram_chk #(
    .ADDR_W   (ADDR_W),
    .COL_W    (COL_W),
    .NCOL     (NCOL),
    .WCLK_INV (WCLK_INV)
) u_chk (.*);

// File: tb/mrport_dram_tb.sv
module mrport_dram_tb;
    logic        clk = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [41:0] nr_addr = '0;
    logic [6:0]  nr_data, nr_data_i;
    logic [1:0]  wide_data, wide_data_i;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] ref_mem [32];

    always #10 clk = ~clk;

    mrport_dram u_dut (
        .wclk(clk), .we(we), .wr_addr(wr_addr), .wr_data(wr_data),
        .nr_addr(nr_addr), .nr_data(nr_data), .wide_data(wide_data));

    mrport_dram #(.WCLK_INV(1'b1)) u_dut_inv (
        .wclk(clk), .we(we), .wr_addr(wr_addr), .wr_data(wr_data),
        .nr_addr(nr_addr), .nr_data(nr_data_i), .wide_data(wide_data_i));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [41:0] all_ports(input logic [4:0] a, input logic [6:0] sels);
        logic [41:0] v;
        for (int k = 0; k < 7; k++) v[k*6 +: 6] = {a, sels[k]};
        return v;
    endfunction

    // Full sweep: every entry, both halves, every port, both instances (R3 R4 R8).
    task automatic sweep(input string req);
        for (int a = 0; a < 32; a++) begin
            for (int s = 0; s < 2; s++) begin
                wr_addr = 5'(a);
                nr_addr = all_ports(5'(a), s[0] ? 7'h7f : 7'h00);
                #1;
                for (int k = 0; k < 7; k++) begin
                    chk(nr_data[k] == ref_mem[a][2*k+s], req, nr_data[k], ref_mem[a][2*k+s]);
                    chk(nr_data_i[k] == ref_mem[a][2*k+s], req, nr_data_i[k], ref_mem[a][2*k+s]);
                end
                chk(wide_data == ref_mem[a][15:14], req, wide_data, ref_mem[a][15:14]);
                chk(wide_data_i == ref_mem[a][15:14], req, wide_data_i, ref_mem[a][15:14]);
            end
        end
    endtask

    // One write cycle with in-window checks (R1 R2 R5 R6).
    task automatic do_write(input logic [4:0] a, input logic [15:0] d, input logic en);
        logic [15:0] old_w, new_w;
        old_w = ref_mem[a];
        new_w = en ? d : old_w;
        @(posedge clk);
        #5;
        we = en; wr_addr = a; wr_data = d;
        nr_addr = all_ports(a, 7'b1010101);
        #10; // after the falling edge, before the rising edge
        chk(wide_data == old_w[15:14], "R5 before edge", wide_data, old_w[15:14]);
        chk(wide_data_i == new_w[15:14], "R6 falling edge", wide_data_i, new_w[15:14]);
        @(posedge clk);
        #2;
        chk(wide_data == new_w[15:14], en ? "R1" : "R2", wide_data, new_w[15:14]);
        for (int k = 0; k < 7; k++) begin
            chk(nr_data[k] == new_w[2*k + (k % 2 == 0 ? 1 : 0)],
                en ? "R5 after edge" : "R2", nr_data[k], new_w[2*k + (k % 2 == 0 ? 1 : 0)]);
        end
        we = 1'b0;
        ref_mem[a] = new_w;
    endtask

    initial begin
        for (int a = 0; a < 32; a++) ref_mem[a] = '0;
        #3;
        sweep("R7 power-up");
        for (int a = 0; a < 32; a++)
            do_write(5'(a), 16'((a * 16'h9E37) ^ 16'hA5A5), 1'b1);
        sweep("R1 R3 R8 fill");
        do_write(5'd0, 16'hAAAA, 1'b1);
        do_write(5'd31, 16'h5555, 1'b1);
        sweep("R3 halves");
        for (int i = 0; i < 24; i++)
            do_write(5'((i * 7 + 3) % 32), 16'((i * 16'h3C5 + 16'h1234) ^ (i << 9)), 1'b1);
        sweep("R8 rewrite");
        for (int i = 0; i < 8; i++)
            do_write(5'(i * 4 + 1), ~ref_mem[i * 4 + 1], 1'b0);
        sweep("R2 disabled");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule